// File: doc/BRIEF.md
# Multi-Slot Task Scheduler Queue

This block schedules work for one processing unit. Pending task records wait in a first-in first-out queue. They arrive either from local spawn requests or from a load-balancing input port. The unit has a fixed set of execution slots, and each slot is in one of four states: free, ready, running or waiting. At most one slot runs at a time. The block drives a current-slot selector that the core uses to choose the register set, program counter and buffer partition.

When the running task blocks on a memory response or quits, the block picks a new slot to run. A slot that has become ready again always wins over starting new work. Only when no slot is ready does the block take the head record from the queue and load it into the lowest-numbered free slot. It announces that start with a one-cycle pulse.

A neighbour that is less busy can pull the head record out through an export handshake. This moves the record from this queue to the neighbour's queue.

Top module: `task_slot_sched`

## Requirements
- R1: After reset, `cur_valid` is 0, `cur_slot` is 0 and `start_valid` is 0. The queue is empty, so `spawn_ready` is 1 and `exp_valid` is 0. All slots are free.
- R2: Records leave the queue, either to a slot or through export, in the order they were accepted. A record is 116 bits laid out as task id [115:84], codelet index [83:68], argument count [67:64] and argument-chunk handle [63:0]. The bits are passed through unchanged.
- R3: `spawn_ready` is low exactly when the queue holds DEPTH records. `bal_in_ready` is low when the queue is full or when `spawn_valid` is high, because the local push has priority. When both are accepted in one cycle, only the local record is stored.
- R4: A slot is vacated when `cur_valid` is low, or when the running task raises `blk_cur` or `quit_cur`. In that cycle, if any slot is ready, then at the next edge `cur_slot` becomes the first ready slot in round-robin order. The search starts one past the previous `cur_slot` and wraps. `cur_valid` becomes 1 and no record leaves the queue.
- R5: A vacated slot with no ready slot, a non-empty queue and a free slot starts the head record on the lowest-numbered free slot. At the next edge `start_valid` pulses for one cycle with `start_slot` and `start_rec`, and `cur_slot` equals `start_slot`. With nothing to run, `cur_valid` drops to 0.
- R6: `blk_cur` moves the running slot to waiting. Bit i of `wake_slot` moves a waiting slot i to ready. That slot can be selected from the following cycle. A wake has no effect on a slot that is not waiting, and it never preempts the running slot.
- R7: `quit_cur` frees the running slot. That slot counts as free in the same cycle, so it can take the next queued record at once.
- R8: `exp_valid` is high when the queue is not empty and no start takes the head in that cycle. `exp_rec` is then the head record. `exp_valid && exp_ready` removes it. `exp_ready` on an empty queue changes nothing.
- R9: `blk_cur` and `quit_cur` have no effect while `cur_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_valid | input | 1 | Local spawn record offered |
| spawn_ready | output | 1 | Queue can accept a local record |
| spawn_rec | input | 116 | Local spawn record |
| bal_in_valid | input | 1 | Record offered by the load balancer |
| bal_in_ready | output | 1 | Queue accepts the balancer record |
| bal_in_rec | input | 116 | Balancer record |
| exp_valid | output | 1 | Head record available for export |
| exp_ready | input | 1 | Neighbour takes the head record |
| exp_rec | output | 116 | Head record |
| blk_cur | input | 1 | Running task waits on memory |
| quit_cur | input | 1 | Running task terminates |
| wake_slot | input | NSLOT | Per-slot wake events |
| cur_valid | output | 1 | A slot is running |
| cur_slot | output | 3 | Current slot selector |
| start_valid | output | 1 | New task loaded this cycle |
| start_slot | output | 3 | Slot receiving the new task |
| start_rec | output | 116 | Record of the new task |

## Verification
The ready signals, `exp_valid` and `exp_rec` are combinational. They respond in the same cycle as the inputs and the queue and slot state, so the bench samples them 1 ns after driving the inputs, before the edge. `cur_valid`, `cur_slot`, the start outputs and every state change appear one edge after the cycle that caused them. The bench samples these at the following falling edge. A cycle-level model in the bench, written from the requirements, advances in step at each edge. A wake issued in the same cycle as a block or quit therefore counts only from the next cycle, and the model predicts that case.

// File: rtl/tsq_pkg.sv
`timescale 1ns/1ps
package tsq_pkg;
  localparam int REC_W = 116;

  typedef struct packed {
    logic [31:0] task_id;
    logic [15:0] code_idx;
    logic [3:0]  arg_cnt;
    logic [63:0] arg_handle;
  } task_rec_t;

  typedef enum logic [1:0] {
    SL_FREE  = 2'd0,
    SL_READY = 2'd1,
    SL_RUN   = 2'd2,
    SL_WAIT  = 2'd3
  } slot_st_e;
endpackage

// File: rtl/tsq_rec_fifo.sv
`timescale 1ns/1ps
module tsq_rec_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 116
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq,
  input  logic [W-1:0] enq_rec,
  input  logic         deq,
  output logic [W-1:0] head_rec,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_d  = enq ? bump(wr_q) : wr_q;
    rd_d  = deq ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (enq && !deq) cnt_d = cnt_q + CW'(1);
    else if (!enq && deq) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (enq) store_q[wr_q] <= enq_rec;
  end

  assign head_rec = store_q[rd_q];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));

  // R3
  enq_full_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> !enq);
  // R8
  deq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) deq |-> !empty);
endmodule

// File: rtl/tsq_rr_pick.sv
`timescale 1ns/1ps
module tsq_rr_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int s;
      s = int'(base) + k;
      if (s >= N) s = s - N;
      if (!found && req[s]) begin
        found = 1'b1;
        idx   = IW'(s);
      end
    end
  end
endmodule

// File: rtl/tsq_slot_table.sv
`timescale 1ns/1ps
module tsq_slot_table
  import tsq_pkg::*;
#(
  parameter int NSLOT = 6,
  parameter int SW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_valid,
  input  logic [SW-1:0]    cur_slot,
  input  logic             blk,
  input  logic             quit,
  input  logic [NSLOT-1:0] wake,
  input  logic             take,
  input  logic [SW-1:0]    take_slot,
  output logic [NSLOT-1:0] ready_mask,
  output logic [NSLOT-1:0] free_mask,
  output logic [NSLOT-1:0] run_mask
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    slot_st_e st_q, st_d;
    logic     is_cur;

    assign is_cur = cur_valid && (cur_slot == SW'(i));

    always_comb begin
      st_d = st_q;
      if (st_q == SL_WAIT && wake[i]) st_d = SL_READY;
      if (is_cur && blk)              st_d = SL_WAIT;
      if (is_cur && quit)             st_d = SL_FREE;
      if (take && take_slot == SW'(i)) st_d = SL_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SL_FREE;
      else        st_q <= st_d;
    end

    assign ready_mask[i] = (st_q == SL_READY);
    assign free_mask[i]  = (st_q == SL_FREE) || (is_cur && quit);
    assign run_mask[i]   = (st_q == SL_RUN);

    // R6
    wake_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SL_WAIT && wake[i]) |=> (st_q == SL_READY));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SL_WAIT && !wake[i]) |=> (st_q == SL_WAIT));
  end

  // R4
  single_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_mask) <= 1);
endmodule

// File: rtl/task_slot_sched.sv
`timescale 1ns/1ps
module task_slot_sched
  import tsq_pkg::*;
#(
  parameter int NSLOT = 6,
  parameter int DEPTH = 8,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spawn_valid,
  output logic             spawn_ready,
  input  logic [REC_W-1:0] spawn_rec,
  input  logic             bal_in_valid,
  output logic             bal_in_ready,
  input  logic [REC_W-1:0] bal_in_rec,
  output logic             exp_valid,
  input  logic             exp_ready,
  output logic [REC_W-1:0] exp_rec,
  input  logic             blk_cur,
  input  logic             quit_cur,
  input  logic [NSLOT-1:0] wake_slot,
  output logic             cur_valid,
  output logic [SW-1:0]    cur_slot,
  output logic             start_valid,
  output logic [SW-1:0]    start_slot,
  output logic [REC_W-1:0] start_rec
);
  logic             q_empty, q_full, q_enq, q_deq;
  logic [REC_W-1:0] q_head, q_in;
  logic [NSLOT-1:0] ready_mask, free_mask, run_mask;
  logic             rdy_found, free_found;
  logic [SW-1:0]    rdy_idx, free_idx;
  logic             vacate, do_switch, do_start, take;
  logic [SW-1:0]    take_slot;

  logic             cur_valid_q, cur_valid_d;
  logic [SW-1:0]    cur_slot_q, cur_slot_d;
  logic             start_valid_q, start_valid_d;
  logic [SW-1:0]    start_slot_q, start_slot_d;
  task_rec_t        start_rec_q, start_rec_d;

  tsq_rec_fifo #(.DEPTH(DEPTH), .W(REC_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .enq(q_enq), .enq_rec(q_in), .deq(q_deq),
    .head_rec(q_head), .empty(q_empty), .full(q_full)
  );

  tsq_slot_table #(.NSLOT(NSLOT), .SW(SW)) slots_i (
    .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid_q), .cur_slot(cur_slot_q),
    .blk(blk_cur), .quit(quit_cur), .wake(wake_slot), .take(take),
    .take_slot(take_slot), .ready_mask(ready_mask), .free_mask(free_mask),
    .run_mask(run_mask)
  );

  tsq_rr_pick #(.N(NSLOT), .IW(SW)) ready_pick_i (
    .req(ready_mask), .base(cur_slot_q), .found(rdy_found), .idx(rdy_idx)
  );

  tsq_rr_pick #(.N(NSLOT), .IW(SW)) free_pick_i (
    .req(free_mask), .base(SW'(NSLOT - 1)), .found(free_found), .idx(free_idx)
  );

  always_comb begin
    vacate    = !cur_valid_q || blk_cur || quit_cur;
    do_switch = vacate && rdy_found;
    do_start  = vacate && !rdy_found && free_found && !q_empty;
    take      = do_switch || do_start;
    take_slot = do_switch ? rdy_idx : free_idx;

    spawn_ready  = !q_full;
    bal_in_ready = !q_full && !spawn_valid;
    q_enq        = (spawn_valid && spawn_ready) || (bal_in_valid && bal_in_ready);
    q_in         = spawn_valid ? spawn_rec : bal_in_rec;

    exp_valid = !q_empty && !do_start;
    exp_rec   = q_head;
    q_deq     = do_start || (exp_valid && exp_ready);
  end

  always_comb begin
    cur_valid_d   = take ? 1'b1 : (vacate ? 1'b0 : cur_valid_q);
    cur_slot_d    = take ? take_slot : cur_slot_q;
    start_valid_d = do_start;
    start_slot_d  = do_start ? free_idx : start_slot_q;
    start_rec_d   = do_start ? task_rec_t'(q_head) : start_rec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid_q   <= 1'b0;
      cur_slot_q    <= '0;
      start_valid_q <= 1'b0;
      start_slot_q  <= '0;
      start_rec_q   <= '0;
    end else begin
      cur_valid_q   <= cur_valid_d;
      cur_slot_q    <= cur_slot_d;
      start_valid_q <= start_valid_d;
      start_slot_q  <= start_slot_d;
      start_rec_q   <= start_rec_d;
    end
  end

  assign cur_valid   = cur_valid_q;
  assign cur_slot    = cur_slot_q;
  assign start_valid = start_valid_q;
  assign start_slot  = start_slot_q;
  assign start_rec   = start_rec_q;

  // R6
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && !blk_cur && !quit_cur) |=> (cur_valid && $stable(cur_slot)));
  // R5
  start_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> (cur_valid && cur_slot == start_slot));
  // R4
  run_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid == (|run_mask));
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |=> !start_valid || $past(!q_empty));
endmodule

// File: tb/task_slot_sched_tb.sv
`timescale 1ns/1ps
module task_slot_sched_tb_top;
  localparam int NS = 6;
  localparam int DP = 4;
  localparam int RW = 116;
  localparam int SWB = 3;

  logic clk, rst_n;
  logic spawn_valid, spawn_ready, bal_in_valid, bal_in_ready;
  logic [RW-1:0] spawn_rec, bal_in_rec, exp_rec, start_rec;
  logic exp_valid, exp_ready, blk_cur, quit_cur;
  logic [NS-1:0] wake_slot;
  logic cur_valid, start_valid;
  logic [SWB-1:0] cur_slot, start_slot;

  int n_chk = 0;
  int n_bad = 0;

  task_slot_sched #(.NSLOT(NS), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .spawn_valid(spawn_valid), .spawn_ready(spawn_ready), .spawn_rec(spawn_rec),
    .bal_in_valid(bal_in_valid), .bal_in_ready(bal_in_ready), .bal_in_rec(bal_in_rec),
    .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_rec(exp_rec),
    .blk_cur(blk_cur), .quit_cur(quit_cur), .wake_slot(wake_slot),
    .cur_valid(cur_valid), .cur_slot(cur_slot),
    .start_valid(start_valid), .start_slot(start_slot), .start_rec(start_rec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench model: 0 free, 1 ready, 2 running, 3 waiting
  int m_st [NS];
  logic [RW-1:0] m_q [$];
  int m_cur;
  bit m_cv, m_sv;
  int m_ss;
  logic [RW-1:0] m_srec;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit pv, input logic [RW-1:0] pr, input bit bv,
                      input logic [RW-1:0] br, input bit er, input bit bk,
                      input bit qt, input logic [NS-1:0] wk);
    bit full, e_sr, e_br, vac, sw, st, e_ev;
    int rdy, fr;
    int ns_st [NS];
    logic [RW-1:0] head;
    spawn_valid = pv; spawn_rec = pr; bal_in_valid = bv; bal_in_rec = br;
    exp_ready = er; blk_cur = bk; quit_cur = qt; wake_slot = wk;
    full = (m_q.size() == DP);
    e_sr = !full;
    e_br = !full && !pv;
    vac  = !m_cv || bk || qt;
    rdy = -1;
    for (int k = 1; k <= NS; k++) begin
      int s;
      s = (m_cur + k) % NS;
      if (rdy < 0 && m_st[s] == 1) rdy = s;
    end
    fr = -1;
    for (int s = 0; s < NS; s++)
      if (fr < 0 && (m_st[s] == 0 || (m_cv && s == m_cur && qt))) fr = s;
    sw = vac && rdy >= 0;
    st = vac && rdy < 0 && fr >= 0 && m_q.size() > 0;
    e_ev = m_q.size() > 0 && !st;
    head = (m_q.size() > 0) ? m_q[0] : '0;
    #1;
    chk("R3 spawn_ready", 128'(spawn_ready), 128'(e_sr));
    chk("R3 bal_in_ready", 128'(bal_in_ready), 128'(e_br));
    chk("R8 exp_valid", 128'(exp_valid), 128'(e_ev));
    if (e_ev) chk("R2 exp_rec order", 128'(exp_rec), 128'(head));
    // advance model across the edge
    for (int s = 0; s < NS; s++) begin
      ns_st[s] = (m_st[s] == 3 && wk[s]) ? 1 : m_st[s];
      if (m_cv && s == m_cur && bk) ns_st[s] = 3;
      if (m_cv && s == m_cur && qt) ns_st[s] = 0;
    end
    if (st || (er && e_ev)) void'(m_q.pop_front());
    if (pv && e_sr) m_q.push_back(pr);
    else if (bv && e_br) m_q.push_back(br);
    if (sw) begin m_cur = rdy; m_cv = 1; ns_st[rdy] = 2; end
    else if (st) begin m_cur = fr; m_cv = 1; ns_st[fr] = 2; end
    else if (vac) m_cv = 0;
    m_sv = st;
    if (st) begin m_ss = fr; m_srec = head; end
    for (int s = 0; s < NS; s++) m_st[s] = ns_st[s];
    @(posedge clk);
    @(negedge clk);
    chk("R4 cur_valid", 128'(cur_valid), 128'(m_cv));
    chk("R4 cur_slot", 128'(cur_slot), 128'(m_cur));
    chk("R5 start_valid", 128'(start_valid), 128'(m_sv));
    if (m_sv) begin
      chk("R5 start_slot", 128'(start_slot), 128'(m_ss));
      chk("R2 start_rec", 128'(start_rec), 128'(m_srec));
    end
  endtask

  function automatic logic [RW-1:0] mkrec(input int n);
    return {32'(n), 16'(n * 3 + 1), 4'(n), 64'(n) * 64'h0001_0000_0001};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    spawn_valid = 0; spawn_rec = '0; bal_in_valid = 0; bal_in_rec = '0;
    exp_ready = 0; blk_cur = 0; quit_cur = 0; wake_slot = '0;
    for (int s = 0; s < NS; s++) m_st[s] = 0;
    m_cur = 0; m_cv = 0; m_sv = 0; m_ss = 0; m_srec = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 cur_valid", 128'(cur_valid), 128'(0));
    chk("R1 cur_slot", 128'(cur_slot), 128'(0));
    chk("R1 start_valid", 128'(start_valid), 128'(0));
    chk("R1 spawn_ready", 128'(spawn_ready), 128'(1));
    chk("R1 exp_valid", 128'(exp_valid), 128'(0));
    @(negedge clk);
    // R8 export on empty queue, R9 block/quit while idle
    step(0, '0, 0, '0, 1, 1, 1, '0);
    // R2 first record goes to slot 0
    step(1, mkrec(1), 0, '0, 0, 0, 0, '0);
    step(0, '0, 0, '0, 0, 0, 0, '0);
    // R3 both ports at once, local first; fill queue
    step(1, mkrec(2), 1, mkrec(90), 0, 0, 0, '0);
    step(0, '0, 1, mkrec(3), 0, 0, 0, '0);
    step(1, mkrec(4), 0, '0, 0, 0, 0, '0);
    step(1, mkrec(5), 0, '0, 0, 0, 0, '0);
    step(1, mkrec(6), 1, mkrec(7), 0, 0, 0, '0);
    // R6 block with no ready slot starts queued work (R5)
    step(0, '0, 0, '0, 0, 1, 0, '0);
    // R6 wake slot 0, no preemption; wake of non-waiting slot ignored
    step(0, '0, 0, '0, 0, 0, 0, 6'b000101);
    // R7 quit: ready slot 0 preferred over queue (R4)
    step(0, '0, 0, '0, 0, 0, 1, '0);
    // R8 export head
    step(0, '0, 0, '0, 1, 0, 0, '0);
    // R7 quit with empty-ready: freed slot reused at once
    step(0, '0, 0, '0, 0, 0, 1, '0);
    for (int i = 0; i < 4000; i++) begin
      bit pv, bv, er, bk, qt;
      logic [NS-1:0] wk;
      pv = ($urandom_range(0, 99) < 30);
      bv = ($urandom_range(0, 99) < 25);
      er = ($urandom_range(0, 99) < 12);
      bk = ($urandom_range(0, 99) < 20);
      qt = ($urandom_range(0, 99) < 12);
      for (int s = 0; s < NS; s++) wk[s] = ($urandom_range(0, 99) < 15);
      step(pv, {$urandom, 16'($urandom), 4'($urandom), $urandom, $urandom},
           bv, {$urandom, 16'($urandom), 4'($urandom), $urandom, $urandom},
           er, bk, qt, wk);
    end
    finish_run();
  end
endmodule